// File: doc/BRIEF.md
# Machine-Check Global Status Controller

This block holds the processor-wide machine-check registers: a read-only capability word, a status word of four flags, and an optional reporting-enable control word. When an error event arrives and reporting is enabled, the block records the event's qualifiers and sets the in-progress flag. It then requests a machine-check exception for one cycle. If another error arrives before software has cleared the in-progress flag, the block enters shutdown instead of requesting a second exception.

Software reaches the three registers through a single select/write/read port. The status word accepts only a write of zero. A write of any other value raises a general-protection fault pulse. The control word accepts only the all-ones pattern (enable) and the all-zeros pattern (disable). The capability word is a parameter. It decides whether the control word exists and whether events may be flagged as delivered only to this logical processor.

Top module: `mcg_status_ctrl`

## Requirements
- R1: After reset, status and control read as zero, and `mce_req`, `shutdown` and `gp_fault` are low.
- R2: The status read value has restart-valid at bit 0, error-IP-valid at bit 1, in-progress at bit 2 and local-signalled at bit 3. Bits 63:4 always read as zero.
- R3: An event accepted while in-progress is clear loads the status with {local, 1, error-IP-valid, restart-valid} at the next edge. `mce_req` is high for exactly that one following cycle.
- R4: An event accepted while in-progress is set asserts `shutdown` at the next edge. It raises no `mce_req` and leaves the status unchanged.
- R5: A status write (select 1) with a nonzero value pulses `gp_fault` for one cycle after the write edge and leaves the status unchanged.
- R6: A status write of zero clears all four flags. The next event then raises a normal exception, not shutdown.
- R7: A control write (select 2) of all ones enables reporting and a write of all zeros disables it. The control reads back as all ones or all zeros accordingly. Any other written value is ignored and the previous state is kept.
- R8: While reporting is disabled, events change neither the status nor `mce_req` nor `shutdown`.
- R9: The capability register (select 0) always reads as `CAP_VALUE`, and writes to it have no effect and raise no fault. Bit 8 of the capability marks the control register as present, and bit 27 marks local delivery as supported.
- R10: The local-signalled flag is set only when the event carries the local qualifier and capability bit 27 is set. Otherwise it stays zero.
- R11: `shutdown` stays high once set, whatever events and writes follow, and only reset clears it.
- R12: When an accepted event and a status write fall in the same cycle, the event's outcome is applied and the write's change to the status is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event strobe |
| evt_restart_ok | input | 1 | Event qualifier: restart address is reliable |
| evt_ip_linked | input | 1 | Event qualifier: pushed address is tied to the error |
| evt_local | input | 1 | Event qualifier: delivered only to this logical processor |
| reg_sel | input | 2 | Register select: 0 capability, 1 status, 2 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| gp_fault | output | 1 | One-cycle fault pulse after an illegal status write |
| mce_req | output | 1 | One-cycle machine-check exception request |
| shutdown | output | 1 | Sticky shutdown indication |

## Verification
The main collision is an error event and a status write in the same cycle. The bench provokes it in two ways. First, it drives an event together with a zero status write while in-progress is set, and expects shutdown with the status left intact. Second, it drives the same pair while in-progress is clear, and expects the event's flags and an exception request rather than a cleared status. A second collision puts an event together with a nonzero status write. In that case the fault pulse and the event's capture must both appear on the following cycle.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

   typedef enum logic [1:0] {
      SEL_CAP  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_NONE = 2'd3
   } mcg_sel_e;

   // Field order matters: software decodes these bit positions.
   typedef struct packed {
      logic local_s;     // bit 3
      logic in_prog;     // bit 2
      logic ip_linked;   // bit 1
      logic restart_ok;  // bit 0
   } mcg_stat_t;

   localparam int STAT_BITS     = 4;
   localparam int CAP_CTL_BIT   = 8;
   localparam int CAP_LOCAL_BIT = 27;

endpackage

// File: rtl/mcg_ctl_reg.sv
module mcg_ctl_reg #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              enable
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr_en) begin
         if (&wdata)
            en_q <= 1'b1;
         else if (wdata == '0)
            en_q <= 1'b0;
      end
   end

   assign enable = en_q;
endmodule

// File: rtl/mcg_stat_reg.sv
module mcg_stat_reg
   import mcg_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter bit LOCAL_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic              evt_restart_ok,
   input  logic              evt_ip_linked,
   input  logic              evt_local,
   input  logic              report_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output mcg_stat_t         stat,
   output logic              mce_req,
   output logic              shutdown,
   output logic              fault
);
   mcg_stat_t stat_q;
   logic      mce_q, shut_q, fault_q;
   logic      local_eff;
   logic      evt_take;

   generate
      if (LOCAL_OK) begin : g_local
         assign local_eff = evt_local;
      end else begin : g_nolocal
         assign local_eff = 1'b0;
      end
   endgenerate

   assign evt_take = evt_valid && report_en && !shut_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= '0;
         mce_q   <= 1'b0;
         shut_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         mce_q   <= 1'b0;
         fault_q <= wr_en && (wdata != '0);
         if (evt_take) begin
            if (stat_q.in_prog) begin
               shut_q <= 1'b1;
            end else begin
               stat_q.local_s    <= local_eff;
               stat_q.in_prog    <= 1'b1;
               stat_q.ip_linked  <= evt_ip_linked;
               stat_q.restart_ok <= evt_restart_ok;
               mce_q             <= 1'b1;
            end
         end else if (wr_en && (wdata == '0)) begin
            stat_q <= '0;
         end
      end
   end

   assign stat     = stat_q;
   assign mce_req  = mce_q;
   assign shutdown = shut_q;
   assign fault    = fault_q;
endmodule

// File: rtl/mcg_status_ctrl.sv
module mcg_status_ctrl
   import mcg_pkg::*;
#(
   parameter int              DATA_W    = 64,
   parameter logic [63:0]     CAP_VALUE = 64'h0000_0000_0800_0104
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic              evt_restart_ok,
   input  logic              evt_ip_linked,
   input  logic              evt_local,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              gp_fault,
   output logic              mce_req,
   output logic              shutdown
);
   localparam bit CTL_PRESENT = CAP_VALUE[CAP_CTL_BIT];
   localparam bit LOCAL_OK    = CAP_VALUE[CAP_LOCAL_BIT];

   generate
      if (DATA_W < CAP_LOCAL_BIT + 1 || DATA_W > 64) begin : g_bad_width
         $error("mcg_status_ctrl: DATA_W must lie in 28..64");
      end
   endgenerate

   mcg_sel_e         sel;
   mcg_stat_t        stat_q;
   logic [3:0]       stat_bits;
   logic             report_en;
   logic             ctl_rd;
   logic             stat_wr;
   logic             ctl_wr;
   logic [DATA_W-1:0] cap_word;

   assign sel       = mcg_sel_e'(reg_sel);
   assign stat_wr   = reg_wr && (sel == SEL_STAT);
   assign ctl_wr    = reg_wr && (sel == SEL_CTL);
   assign cap_word  = CAP_VALUE[DATA_W-1:0];
   assign stat_bits = stat_q;

   generate
      if (CTL_PRESENT) begin : g_ctl
         mcg_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ctl_wr),
            .wdata  (reg_wdata),
            .enable (report_en)
         );
         assign ctl_rd = report_en;
      end else begin : g_no_ctl
         assign report_en = 1'b1;
         assign ctl_rd    = 1'b0;
      end
   endgenerate

   mcg_stat_reg #(.DATA_W(DATA_W), .LOCAL_OK(LOCAL_OK)) u_stat (
      .clk            (clk),
      .rst_n          (rst_n),
      .evt_valid      (evt_valid),
      .evt_restart_ok (evt_restart_ok),
      .evt_ip_linked  (evt_ip_linked),
      .evt_local      (evt_local),
      .report_en      (report_en),
      .wr_en          (stat_wr),
      .wdata          (reg_wdata),
      .stat           (stat_q),
      .mce_req        (mce_req),
      .shutdown       (shutdown),
      .fault          (gp_fault)
   );

   always_comb begin
      case (sel)
         SEL_CAP:  reg_rdata = cap_word;
         SEL_STAT: reg_rdata = {{(DATA_W-STAT_BITS){1'b0}}, stat_q};
         SEL_CTL:  reg_rdata = {DATA_W{ctl_rd}};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mcg_status_ctrl_chk.sv
module mcg_status_ctrl_chk #(
   parameter int          DATA_W    = 64,
   parameter logic [63:0] CAP_VALUE = 64'h0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              mce_req,
   input logic              shutdown,
   input logic              gp_fault,
   input logic              report_en,
   input logic [3:0]        stat_bits
);
   assert_status_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd1) |-> (reg_rdata[DATA_W-1:4] == '0));

   assert_accept_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && report_en && !stat_bits[2] && !shutdown) |=> (mce_req && stat_bits[2]));

   assert_mce_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mce_req |=> !mce_req);

   assert_second_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && report_en && stat_bits[2] && !shutdown) |=> (shutdown && !mce_req && $stable(stat_bits)));

   assert_bad_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd1 && reg_wdata != '0 && !evt_valid) |=> (gp_fault && $stable(stat_bits)));

   assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !report_en && !reg_wr) |=> (!mce_req && $stable(stat_bits) && $stable(shutdown)));

   assert_cap_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd0) |-> (reg_rdata == CAP_VALUE[DATA_W-1:0]));

   assert_shutdown_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> shutdown);
endmodule

bind mcg_status_ctrl mcg_status_ctrl_chk #(.DATA_W(DATA_W), .CAP_VALUE(CAP_VALUE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .mce_req   (mce_req),
   .shutdown  (shutdown),
   .gp_fault  (gp_fault),
   .report_en (report_en),
   .stat_bits (stat_bits)
);

// File: tb/tb_mcg_status_ctrl.sv
module tb_mcg_status_ctrl;
   localparam int          CLK_PERIOD = 10;
   localparam int          DW         = 64;
   localparam logic [63:0] CAP_A      = 64'h0000_0000_0800_0104;
   localparam logic [63:0] CAP_B      = 64'h0000_0000_0000_0104;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0, evt_restart_ok = 1'b0, evt_ip_linked = 1'b0, evt_local = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] rdata_a, rdata_b;
   logic          fault_a, mce_a, shut_a, fault_b, mce_b, shut_b;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcg_status_ctrl #(.DATA_W(DW), .CAP_VALUE(CAP_A)) dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_restart_ok(evt_restart_ok),
      .evt_ip_linked(evt_ip_linked), .evt_local(evt_local), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .gp_fault(fault_a), .mce_req(mce_a),
      .shutdown(shut_a));

   mcg_status_ctrl #(.DATA_W(DW), .CAP_VALUE(CAP_B)) dut_noloc (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_restart_ok(evt_restart_ok),
      .evt_ip_linked(evt_ip_linked), .evt_local(evt_local), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .gp_fault(fault_b), .mce_req(mce_b),
      .shutdown(shut_b));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus at the falling edge; return just after the rising edge.
   task automatic drive(input logic ev, input logic r, input logic i, input logic l,
                        input logic wr, input logic [1:0] sel, input logic [63:0] d);
      @(negedge clk);
      evt_valid = ev; evt_restart_ok = r; evt_ip_linked = i; evt_local = l;
      reg_wr = wr; reg_sel = sel; reg_wdata = d;
      @(posedge clk); #1;
      evt_valid = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, reg_sel, '0);
   endtask

   task automatic rd(input logic [1:0] sel, output logic [63:0] a, output logic [63:0] b);
      reg_sel = sel; #1;
      a = rdata_a; b = rdata_b;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1; rst_n = 1'b1;
   endtask

   function automatic logic [63:0] stat_exp(input logic r, input logic i, input logic l);
      return 64'(l) << 3 | 64'h4 | 64'(i) << 1 | 64'(r);
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [63:0] a, b, held;
      do_reset();

      // R1 reset state
      rd(2'd1, a, b); check("R1 status", a, 64'h0);
      rd(2'd2, a, b); check("R1 control", a, 64'h0);
      check("R1 outputs", {61'h0, fault_a, mce_a, shut_a}, 64'h0);

      // R9 capability constant and write-immune
      rd(2'd0, a, b); check("R9 cap A", a, CAP_A); check("R9 cap B", b, CAP_B);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd0, '1);
      check("R9 no fault", 64'(fault_a), 64'h0);
      rd(2'd0, a, b); check("R9 cap after write", a, CAP_A);

      // R8 disabled: event ignored
      drive(1'b1, 1, 1, 1, 1'b0, 2'd1, '0);
      check("R8 no mce", {62'h0, mce_a, shut_a}, 64'h0);
      rd(2'd1, a, b); check("R8 status", a, 64'h0);

      // R7 control patterns
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, 64'h5555_5555_5555_5555);
      rd(2'd2, a, b); check("R7 odd pattern ignored", a, 64'h0);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, '1);
      rd(2'd2, a, b); check("R7 enable", a, '1);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, 64'h1);
      rd(2'd2, a, b); check("R7 kept on", a, '1);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, '0);
      rd(2'd2, a, b); check("R7 disable", a, '0);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFE);
      rd(2'd2, a, b); check("R7 kept off", a, '0);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, '1);

      // R3 / R10 / R2 / R6 sweep over all qualifier combinations
      for (int c = 0; c < 8; c++) begin
         drive(1'b0, 0, 0, 0, 1'b1, 2'd1, '0);
         rd(2'd1, a, b); check("R6 cleared", a, 64'h0);
         drive(1'b1, c[0], c[1], c[2], 1'b0, 2'd1, '0);
         check("R3 mce", 64'(mce_a), 64'h1);
         check("R6 no shutdown", 64'(shut_a), 64'h0);
         rd(2'd1, a, b);
         check("R3 R2 status", a, stat_exp(c[0], c[1], c[2]));
         check("R10 local gated", b, stat_exp(c[0], c[1], 1'b0));
         idle();
         check("R3 single pulse", 64'(mce_a), 64'h0);
      end

      // R4 second event -> shutdown; R11 sticky
      rd(2'd1, a, b); held = a;
      drive(1'b1, 0, 0, 0, 1'b0, 2'd1, '0);
      check("R4 shutdown", 64'(shut_a), 64'h1);
      check("R4 no mce", 64'(mce_a), 64'h0);
      rd(2'd1, a, b); check("R4 status kept", a, held);
      drive(1'b0, 0, 0, 0, 1'b1, 2'd1, '0);
      drive(1'b1, 1, 1, 0, 1'b0, 2'd1, '0);
      check("R11 sticky", {62'h0, shut_a, mce_a}, 64'h2);
      rd(2'd1, a, b); check("R11 event ignored", a, 64'h0);
      do_reset();
      check("R11 reset clears", 64'(shut_a), 64'h0);

      // R5 nonzero status writes, all single-bit values
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, '1);
      drive(1'b1, 1, 0, 1, 1'b0, 2'd1, '0);
      held = stat_exp(1, 0, 1);
      for (int k = 0; k < DW; k++) begin
         drive(1'b0, 0, 0, 0, 1'b1, 2'd1, 64'h1 << k);
         check("R5 fault", 64'(fault_a), 64'h1);
         rd(2'd1, a, b); check("R5 status kept", a, held);
      end
      idle();
      check("R5 fault pulse ends", 64'(fault_a), 64'h0);

      // R6 zero write then normal exception
      drive(1'b0, 0, 0, 0, 1'b1, 2'd1, '0);
      check("R6 no fault", 64'(fault_a), 64'h0);
      drive(1'b1, 0, 1, 0, 1'b0, 2'd1, '0);
      check("R6 normal exception", {62'h0, mce_a, shut_a}, 64'h2);

      // R12 event + zero write while in progress -> shutdown, status intact
      rd(2'd1, a, b); held = a;
      drive(1'b1, 1, 1, 1, 1'b1, 2'd1, '0);
      check("R12 shutdown wins", 64'(shut_a), 64'h1);
      rd(2'd1, a, b); check("R12 status intact", a, held);

      // R12 event + zero write while idle -> event captured
      do_reset();
      drive(1'b0, 0, 0, 0, 1'b1, 2'd2, '1);
      drive(1'b1, 1, 0, 1, 1'b1, 2'd1, '0);
      check("R12 mce", 64'(mce_a), 64'h1);
      rd(2'd1, a, b); check("R12 event kept", a, stat_exp(1, 0, 1));

      // R12 / R5 event + nonzero write: fault and capture both appear
      drive(1'b0, 0, 0, 0, 1'b1, 2'd1, '0);
      drive(1'b1, 0, 1, 0, 1'b1, 2'd1, 64'h8);
      check("R5 fault with event", {62'h0, fault_a, mce_a}, 64'h3);
      rd(2'd1, a, b); check("R12 capture with bad write", a, stat_exp(0, 1, 0));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule